// File: doc/BRIEF.md
# DDR SDRAM Start-Up Command Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM with 4096 rows and 512 columns per bank. It leaves reset holding the clock-enable pin low and then works through the fixed start-up procedure on the command bus. That bus is made of clock enable, chip select, row strobe, column strobe, write enable, a two-bit bank address and a twelve-bit address. When the procedure is finished, the block raises `init_done` and only issues NOP from then on. A separate flag, `read_ok`, reports when the DLL has had enough cycles since its reset for reads to be legal.

Every delay is a parameter counted in controller clock cycles: the stable-clock wait, the precharge gap, the mode-register gap, the refresh gap and the DLL lock count. The base and extended mode register contents are also parameters. The sequencer itself forces the DLL-reset bit (address bit 8 of the base register) and the DLL-disable bit (address bit 0 of the extended register). A synchronous active-low reset restarts the whole procedure from the beginning.

Cycles are numbered from 0, where cycle 0 is the first clock cycle after `rst_n` goes high. S is the stable-clock count. Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows:

| Command | cs_n ras_n cas_n we_n |
|---|---|
| Deselect | 1111 |
| NOP | 0111 |
| Precharge | 0010 |
| Auto-refresh | 0001 |
| Load mode register | 0000 |

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, and for cycles 0 to S-1 after it, `cke` is 0, the command is Deselect (1111) with bank and address zero, and `init_done` and `read_ok` are 0.
- R2: In cycle S, `cke` becomes 1 and the command is NOP (0111). From then on, `cke` stays 1 until the next reset.
- R3: In cycle S+1 the first Precharge (0010) is issued with bank 00 and address 0x400, so A10 is 1 and all banks are selected. Exactly T_RP NOP cycles follow.
- R4: The next command is a load mode register (0000) to the extended register (bank 01). Its address is the extended value with bit 0 cleared, which enables the DLL. Exactly T_MRD NOP cycles follow.
- R5: The next command is a load mode register to the base register (bank 00). Its address is the base value with bit 8 set, which resets the DLL. Exactly T_MRD NOP cycles follow.
- R6: The next command is a second all-bank Precharge (0010, address 0x400). Exactly T_RP NOP cycles follow.
- R7: Two Auto-refresh commands (0001, bank and address zero) come next. Each is followed by exactly T_RFC NOP cycles.
- R8: The last command is a load mode register to the base register (bank 00) with bit 8 cleared. After exactly T_MRD NOP cycles, `init_done` rises and stays high. While `init_done` is high, only NOP is issued, with `cke` at 1.
- R9: `read_ok` first goes high exactly T_DLL cycles after the cycle of the DLL-reset command (R5), and it stays high until reset.
- R10: Asserting `rst_n` low in any cycle drives the outputs to their R1 values at the next clock edge. The sequence then restarts from cycle 0.
- R11: Each command lasts exactly one cycle. Between cycle S and `init_done`, every cycle that carries none of the seven commands is a NOP with bank and address zero, so the run contains exactly seven commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset, restarts the sequence |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus, carries mode register contents |
| init_done | output | 1 | Start-up procedure complete |
| read_ok | output | 1 | DLL lock time since DLL reset has expired |

## Verification
All bus outputs are decoded from one state register, so a value changes at the rising edge that ends the previous cycle and holds for the whole cycle. The bench works out the cycle of each command from the parameters: S+1, then each later command one cycle plus its gap after the one before it. `read_ok` is due at T_DLL past the DLL-reset cycle, and `init_done` at T_MRD+1 past the final mode load. The bench changes inputs and samples outputs only on falling edges, and it compares every cycle of a full run against those figures. A reset asserted at a falling edge is checked at the next falling edge, one register later. This is repeated for a reset in every cycle of the run.

// File: rtl/ddr_init_pkg.sv
// Shared types for the DDR start-up sequencer.
// Assumes the usual {cs_n, ras_n, cas_n, we_n} command coding.
package ddr_init_pkg;

    typedef enum logic [3:0] {
        CMD_LMR   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } ddr_cmd_e;

    typedef enum logic [4:0] {
        ST_STABLE,
        ST_CKE_NOP,
        ST_PRE1,
        ST_WRP1,
        ST_EMR,
        ST_WMRD1,
        ST_MRRST,
        ST_WMRD2,
        ST_PRE2,
        ST_WRP2,
        ST_REF1,
        ST_WRFC1,
        ST_REF2,
        ST_WRFC2,
        ST_MRCLR,
        ST_WMRD3,
        ST_DONE
    } step_e;

    typedef struct packed {
        logic       cke;
        ddr_cmd_e   cmd;
        logic [1:0] ba;
        logic [11:0] addr;
    } cmd_bus_t;

    localparam logic [1:0] BA_BASE   = 2'b00;
    localparam logic [1:0] BA_EXT    = 2'b01;
    localparam int         ALL_BIT   = 10;
    localparam int         DLLRST_BIT = 8;
    localparam int         DLLDIS_BIT = 0;

endpackage

// File: rtl/ddr_init_timer.sv
// Down-counter for the wait between commands.
// It loads on the cycle a command is driven and counts down to zero, then holds.
// On reset it takes RST_VAL, which is the stable-clock wait.
module ddr_init_timer #(
    parameter int CW      = 16,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Reload on a command, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ddr_init_fsm.sv
// Step register for the start-up procedure.
// Each command state lasts one cycle and loads the timer with gap-1.
// Each wait state moves on once the timer reads zero.
// Assumes every gap parameter is at least 1.
module ddr_init_fsm
    import ddr_init_pkg::*;
#(
    parameter int CW    = 16,
    parameter int T_RP  = 3,
    parameter int T_MRD = 2,
    parameter int T_RFC = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmr_zero,
    output step_e         step,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);
    localparam logic [CW-1:0] GAP_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] GAP_MRD = CW'(T_MRD - 1);
    localparam logic [CW-1:0] GAP_RFC = CW'(T_RFC - 1);

    step_e nxt;

    // Pick the next step and the timer load for a command.
    always_comb begin
        nxt      = step;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (step)
            ST_STABLE:  if (tmr_zero) nxt = ST_CKE_NOP;
            ST_CKE_NOP: nxt = ST_PRE1;
            ST_PRE1: begin
                nxt = ST_WRP1; tmr_load = 1'b1; tmr_val = GAP_RP;
            end
            ST_WRP1:    if (tmr_zero) nxt = ST_EMR;
            ST_EMR: begin
                nxt = ST_WMRD1; tmr_load = 1'b1; tmr_val = GAP_MRD;
            end
            ST_WMRD1:   if (tmr_zero) nxt = ST_MRRST;
            ST_MRRST: begin
                nxt = ST_WMRD2; tmr_load = 1'b1; tmr_val = GAP_MRD;
            end
            ST_WMRD2:   if (tmr_zero) nxt = ST_PRE2;
            ST_PRE2: begin
                nxt = ST_WRP2; tmr_load = 1'b1; tmr_val = GAP_RP;
            end
            ST_WRP2:    if (tmr_zero) nxt = ST_REF1;
            ST_REF1: begin
                nxt = ST_WRFC1; tmr_load = 1'b1; tmr_val = GAP_RFC;
            end
            ST_WRFC1:   if (tmr_zero) nxt = ST_REF2;
            ST_REF2: begin
                nxt = ST_WRFC2; tmr_load = 1'b1; tmr_val = GAP_RFC;
            end
            ST_WRFC2:   if (tmr_zero) nxt = ST_MRCLR;
            ST_MRCLR: begin
                nxt = ST_WMRD3; tmr_load = 1'b1; tmr_val = GAP_MRD;
            end
            ST_WMRD3:   if (tmr_zero) nxt = ST_DONE;
            ST_DONE:    nxt = ST_DONE;
            default:    nxt = ST_STABLE;
        endcase
    end

    // Step register with synchronous restart.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= ST_STABLE;
        else        step <= nxt;
    end
endmodule

// File: rtl/ddr_init_cmd_enc.sv
// Maps the current step onto the memory command bus.
// Forces the DLL bits: the extended register is sent with DLL enabled,
// and the base register is sent with DLL-reset set once and then cleared.
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
#(
    parameter logic [11:0] MR_VAL  = 12'h032,
    parameter logic [11:0] EMR_VAL = 12'h000
) (
    input  step_e    step,
    output cmd_bus_t bus
);
    localparam logic [11:0] A_ALL    = 12'(1) << ALL_BIT;
    localparam logic [11:0] A_EXT    = EMR_VAL & ~(12'(1) << DLLDIS_BIT);
    localparam logic [11:0] A_MR_RST = MR_VAL | (12'(1) << DLLRST_BIT);
    localparam logic [11:0] A_MR_CLR = MR_VAL & ~(12'(1) << DLLRST_BIT);

    // Decode one step into clock enable, command, bank and address.
    always_comb begin
        bus.cke  = 1'b1;
        bus.cmd  = CMD_NOP;
        bus.ba   = 2'b00;
        bus.addr = '0;
        case (step)
            ST_STABLE: begin
                bus.cke = 1'b0;
                bus.cmd = CMD_DESEL;
            end
            ST_PRE1, ST_PRE2: begin
                bus.cmd  = CMD_PRE;
                bus.addr = A_ALL;
            end
            ST_EMR: begin
                bus.cmd  = CMD_LMR;
                bus.ba   = BA_EXT;
                bus.addr = A_EXT;
            end
            ST_MRRST: begin
                bus.cmd  = CMD_LMR;
                bus.ba   = BA_BASE;
                bus.addr = A_MR_RST;
            end
            ST_MRCLR: begin
                bus.cmd  = CMD_LMR;
                bus.ba   = BA_BASE;
                bus.addr = A_MR_CLR;
            end
            ST_REF1, ST_REF2: bus.cmd = CMD_REF;
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr_init_dll_guard.sv
// Read-permit timer. It is armed by the DLL-reset command cycle and raises
// read_ok exactly T_DLL cycles later. It stays high until reset.
module ddr_init_dll_guard #(
    parameter int T_DLL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic read_ok
);
    localparam int DW = $clog2(T_DLL + 1);

    logic          armed;
    logic [DW-1:0] cnt;

    // Start the count on the DLL reset, then run it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            cnt   <= DW'(T_DLL - 1);
        end else if (armed && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign read_ok = armed && (cnt == '0);
endmodule

// File: rtl/ddr_init_seq.sv
// Top of the DDR start-up sequencer. It ties the step register, the gap
// timer, the command decoder and the read-permit timer together.
// Assumes all timing parameters are at least 1, counted in controller clocks.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int          T_STABLE = 50000,
    parameter int          T_RP     = 3,
    parameter int          T_MRD    = 2,
    parameter int          T_RFC    = 18,
    parameter int          T_DLL    = 200,
    parameter logic [11:0] MR_VAL   = 12'h032,
    parameter logic [11:0] EMR_VAL  = 12'h000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        cke,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [11:0] addr,
    output logic        init_done,
    output logic        read_ok
);
    localparam int CW = $clog2(T_STABLE + T_RP + T_MRD + T_RFC + 2);

    step_e         step;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    cmd_bus_t      bus;

    ddr_init_fsm #(.CW(CW), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tmr_zero(tmr_zero),
        .step(step), .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    ddr_init_timer #(.CW(CW), .RST_VAL(T_STABLE - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );

    ddr_init_cmd_enc #(.MR_VAL(MR_VAL), .EMR_VAL(EMR_VAL)) u_enc (
        .step(step), .bus(bus)
    );

    ddr_init_dll_guard #(.T_DLL(T_DLL)) u_guard (
        .clk(clk), .rst_n(rst_n), .arm(step == ST_MRRST), .read_ok(read_ok)
    );

    // Drive the pins straight from the decoded bus.
    always_comb begin
        cke   = bus.cke;
        {cs_n, ras_n, cas_n, we_n} = bus.cmd;
        ba    = bus.ba;
        addr  = bus.addr;
    end

    assign init_done = (step == ST_DONE);
endmodule

// File: rtl/ddr_init_chk.sv
// Property checker for ddr_init_seq. It looks only at the ports and is bound to every instance.
module ddr_init_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cke,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [11:0] addr,
    input logic        init_done,
    input logic        read_ok
);
    logic [3:0] cmd;
    logic       is_cmd;
    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_cmd = (cs_n == 1'b0) && (cmd != 4'b0111);

    p_clock_off_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cs_n);
    p_cke_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);
    p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> addr[10]);
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && cmd == 4'b0111));
    p_read_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        read_ok |=> read_ok);
    p_single_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> (cmd == 4'b0111));
endmodule

bind ddr_init_seq ddr_init_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .init_done(init_done),
    .read_ok(read_ok)
);

// File: tb/test_ddr_init_seq.sv
// Bench for ddr_init_seq, run with a short configuration. It computes every expected
// cycle from the parameters and checks a full run cycle by cycle. It then
// asserts reset in each cycle of the run and checks the restart.
module test_ddr_init_seq;
    localparam int TS  = 20;
    localparam int RP  = 3;
    localparam int MRD = 2;
    localparam int RFC = 7;
    localparam int DLL = 40;
    localparam logic [11:0] MRV  = 12'h132;
    localparam logic [11:0] EMRV = 12'h003;

    localparam int E0 = TS + 1;
    localparam int E1 = E0 + RP + 1;
    localparam int E2 = E1 + MRD + 1;
    localparam int E3 = E2 + MRD + 1;
    localparam int E4 = E3 + RP + 1;
    localparam int E5 = E4 + RFC + 1;
    localparam int E6 = E5 + RFC + 1;
    localparam int DONE_C = E6 + MRD + 1;
    localparam int RDY_C  = E2 + DLL;
    localparam int RUN    = RDY_C + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done, read_ok;
    logic [1:0]  ba;
    logic [11:0] addr;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    ddr_init_seq #(.T_STABLE(TS), .T_RP(RP), .T_MRD(MRD), .T_RFC(RFC),
                   .T_DLL(DLL), .MR_VAL(MRV), .EMR_VAL(EMRV)) i_ddr_init_seq (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .init_done(init_done), .read_ok(read_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [17:0] exp_bus(input int c);
        if (c < TS)       return {4'b1111, 2'b00, 12'h000};
        if (c == E0 || c == E3) return {4'b0010, 2'b00, 12'h400};
        if (c == E1)      return {4'b0000, 2'b01, 12'h002};
        if (c == E2)      return {4'b0000, 2'b00, 12'h132};
        if (c == E4 || c == E5) return {4'b0001, 2'b00, 12'h000};
        if (c == E6)      return {4'b0000, 2'b00, 12'h032};
        return {4'b0111, 2'b00, 12'h000};
    endfunction

    function automatic string req_of(input int c);
        if (c < TS)  return "R1";
        if (c == TS) return "R2";
        if (c == E0) return "R3";
        if (c == E1) return "R4";
        if (c == E2) return "R5";
        if (c == E3) return "R6";
        if (c == E4 || c == E5) return "R7";
        if (c == E6) return "R8";
        return "R11";
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ev_c [8];
        int nev;
        int mins [6];
        mins = '{RP, MRD, MRD, RP, RFC, RFC};
        nev = 0;

        // R1: state held during reset
        repeat (3) @(negedge clk);
        chk("R1 reset", {28'd0, cke, cs_n, init_done, read_ok}, 32'b0100);
        rst_n = 1'b1;

        // Full run, cycle by cycle
        for (int c = 0; c < RUN; c++) begin
            chk(req_of(c), {14'd0, cs_n, ras_n, cas_n, we_n, ba, addr}, {14'd0, exp_bus(c)});
            chk(c < TS ? "R1 cke" : "R2 cke", {31'd0, cke}, {31'd0, (c >= TS)});
            chk("R8 done", {31'd0, init_done}, {31'd0, (c >= DONE_C)});
            chk("R9 read_ok", {31'd0, read_ok}, {31'd0, (c >= RDY_C)});
            if (!cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
                if (nev < 8) ev_c[nev] = c;
                nev++;
            end
            @(negedge clk);
        end

        // R11: seven commands, gaps at least their minimums
        chk("R11 count", nev, 7);
        if (nev == 7) begin
            for (int i = 0; i < 6; i++)
                chk("R11 gap", {31'd0, (ev_c[i+1] - ev_c[i] - 1 >= mins[i])}, 32'd1);
        end

        // R10: reset in every cycle of the run
        for (int k = 0; k <= RDY_C + 2; k++) begin
            do_reset();
            repeat (k) @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            chk("R10 restart", {28'd0, cke, cs_n, init_done, read_ok}, 32'b0100);
            rst_n = 1'b1;
            repeat (TS - 1) @(negedge clk);
            chk("R10 cke low", {31'd0, cke}, 32'd0);
            @(negedge clk);
            chk("R10 nop", {27'd0, cke, cs_n, ras_n, cas_n, we_n}, 32'b10111);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule